// File: doc/BRIEF.md
# E-paper Gate Row Scan Sequencer

This block produces the vertical-scan control for an active-matrix e-paper panel whose row driver is a shift register. When the block is idle, a one-cycle start request begins a frame. The block raises the gate output enable and issues an active-low vertical start pulse. This pulse lasts one complete row-clock period and loads a single active bit into the row driver. The block then keeps clocking the row driver. Each row-clock pulse after the first moves the selected row on by one.

The row clock has independently programmable high and low durations. The high time is the only window in which a row's transistors conduct, so it is normally set much shorter than the low time to avoid leakage into neighbouring rows. At the first cycle of every low phase the block emits a one-cycle row strobe. The source-data path uses this strobe to shift and latch the next row's pixels. The block reports busy for the whole scan and pulses done once when the scan ends.

Top module: `epd_row_scan`

## Requirements
- R1: While reset is asserted and afterwards while idle, gate_en_o is 0, vstart_n_o is 1, row_clk_o is 0, row_strobe_o is 0, busy_o is 0 and done_o is 0.
- R2: A start_i seen at a clock edge while idle begins a frame, and busy_o is 1 from the next cycle onward. A start_i seen while busy_o is 1 has no effect on any output.
- R3: gate_en_o and busy_o are 1 in every cycle of the frame, from the cycle after the accepted start through the last cycle of the final low phase.
- R4: vstart_n_o is 0 for exactly the first row-clock period of the frame (its high phase plus its low phase). It is 1 at all other times.
- R5: A frame contains exactly N row-clock pulses, where N is the row count. Each pulse is high for H cycles and then low for L cycles, where H and L are the programmed high and low counts. The first high cycle is the cycle after the accepted start.
- R6: row_strobe_o is 1 for one cycle, in the first cycle of each low phase, and is 0 otherwise.
- R7: In the cycle after the final low phase, done_o is 1 for one cycle, and gate_en_o, busy_o and row_clk_o are 0. The block is then idle and accepts a new start.
- R8: The row count, high count and low count are captured when a start is accepted. Changes to them during a frame do not alter that frame.
- R9: A programmed count of 0 (row count, high count or low count) is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle frame start request |
| rows_i | input | ROW_W | Number of rows per frame |
| hi_cyc_i | input | CNT_W | Row-clock high duration in clock cycles |
| lo_cyc_i | input | CNT_W | Row-clock low duration in clock cycles |
| gate_en_o | output | 1 | Gate output enable, high during the scan |
| vstart_n_o | output | 1 | Active-low vertical start pulse |
| row_clk_o | output | 1 | Row clock to the gate shift register |
| row_strobe_o | output | 1 | One-cycle strobe at each low-phase start |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions check on every cycle the local relations between outputs. The start pulse occurs only with the gate enabled. The strobe follows a falling row clock. Done lasts one cycle and coincides with the gate enable falling. The row clock and start pulse are quiet while idle, and an accepted start produces its first high cycle at once. Only the bench's scenarios can show the counted properties. These are the number of pulses per frame, the exact high and low lengths, the treatment of zero settings, and the fact that start requests and setting changes during a frame leave the waveform unchanged. The bench sweeps small row, high and low counts and compares every cycle against an arithmetic model.

// File: rtl/epd_scan_pkg.sv
package epd_scan_pkg;
  typedef enum logic [1:0] {
    SCAN_IDLE = 2'd0,
    SCAN_HIGH = 2'd1,
    SCAN_LOW  = 2'd2
  } scan_state_e;
endpackage

// File: rtl/epd_rst_sync.sv
module epd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync_o = sync_q[1];
endmodule

// File: rtl/epd_phase_timer.sv
module epd_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             tc_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // lim_i is never zero: the top substitutes 1 for a programmed 0
  assign tc_o = (cnt_q == lim_i - 1'b1);
endmodule

// File: rtl/epd_row_tracker.sv
module epd_row_tracker #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [ROW_W-1:0] rows_i,
  output logic             first_o,
  output logic             last_o
);
  logic [ROW_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (clr_i)      idx_d = '0;
    else if (adv_i) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign first_o = (idx_q == '0);
  assign last_o  = (idx_q == rows_i - 1'b1);
endmodule

// File: rtl/epd_row_scan.sv
module epd_row_scan
  import epd_scan_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [ROW_W-1:0] rows_i,
  input  logic [CNT_W-1:0] hi_cyc_i,
  input  logic [CNT_W-1:0] lo_cyc_i,
  output logic             gate_en_o,
  output logic             vstart_n_o,
  output logic             row_clk_o,
  output logic             row_strobe_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             rst_n_s;
  scan_state_e      state_q, state_d;
  logic [ROW_W-1:0] rows_q;
  logic [CNT_W-1:0] hi_q, lo_q, lim;
  logic             accept, tc, phase_end, row_adv;
  logic             first_row, last_row;
  logic             done_d, strobe_d;

  epd_rst_sync u_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_s)
  );

  assign accept    = (state_q == SCAN_IDLE) && start_i;
  assign phase_end = (state_q != SCAN_IDLE) && tc;
  assign row_adv   = (state_q == SCAN_LOW) && tc;
  assign lim       = (state_q == SCAN_HIGH) ? hi_q : lo_q;

  // settings captured only on an accepted start; zero promoted to one
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rows_q <= ROW_ONE;
      hi_q   <= CNT_ONE;
      lo_q   <= CNT_ONE;
    end else if (accept) begin
      rows_q <= (rows_i   == '0) ? ROW_ONE : rows_i;
      hi_q   <= (hi_cyc_i == '0) ? CNT_ONE : hi_cyc_i;
      lo_q   <= (lo_cyc_i == '0) ? CNT_ONE : lo_cyc_i;
    end
  end

  epd_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr_i (accept || phase_end),
    .en_i  (state_q != SCAN_IDLE),
    .lim_i (lim),
    .tc_o  (tc)
  );

  epd_row_tracker #(.ROW_W(ROW_W)) u_rows (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr_i   (accept),
    .adv_i   (row_adv),
    .rows_i  (rows_q),
    .first_o (first_row),
    .last_o  (last_row)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SCAN_IDLE: if (start_i) state_d = SCAN_HIGH;
      SCAN_HIGH: if (tc)      state_d = SCAN_LOW;
      SCAN_LOW:  if (tc)      state_d = last_row ? SCAN_IDLE : SCAN_HIGH;
      default:                state_d = SCAN_IDLE;
    endcase
  end

  assign done_d   = row_adv && last_row;
  assign strobe_d = (state_q == SCAN_HIGH) && tc;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q      <= SCAN_IDLE;
      done_o       <= 1'b0;
      row_strobe_o <= 1'b0;
    end else begin
      state_q      <= state_d;
      done_o       <= done_d;
      row_strobe_o <= strobe_d;
    end
  end

  assign busy_o     = (state_q != SCAN_IDLE);
  assign gate_en_o  = busy_o;
  assign row_clk_o  = (state_q == SCAN_HIGH);
  assign vstart_n_o = !(busy_o && first_row);
endmodule

// File: rtl/epd_row_scan_chk.sv
module epd_row_scan_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic gate_en_o,
  input logic vstart_n_o,
  input logic row_clk_o,
  input logic row_strobe_o,
  input logic busy_o,
  input logic done_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!row_clk_o && vstart_n_o && !gate_en_o && !row_strobe_o)); // R1

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !done_o && $past(!busy_o)) |=> (busy_o && row_clk_o && !vstart_n_o)); // R2

  AST_GATE_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en_o == busy_o); // R3

  AST_VSTART_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !vstart_n_o |-> gate_en_o); // R4

  AST_STROBE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    row_strobe_o |-> ($past(row_clk_o) && !row_clk_o && busy_o)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_DONE_ENDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_en_o) |-> done_o); // R7
endmodule

bind epd_row_scan epd_row_scan_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .gate_en_o    (gate_en_o),
  .vstart_n_o   (vstart_n_o),
  .row_clk_o    (row_clk_o),
  .row_strobe_o (row_strobe_o),
  .busy_o       (busy_o),
  .done_o       (done_o)
);

// File: tb/epd_row_scan_tb.sv
module epd_row_scan_tb;
  localparam int ROW_W = 11;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [ROW_W-1:0] rows_i = '0;
  logic [CNT_W-1:0] hi_cyc_i = '0;
  logic [CNT_W-1:0] lo_cyc_i = '0;
  logic gate_en_o, vstart_n_o, row_clk_o, row_strobe_o, busy_o, done_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  epd_row_scan #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rows_i(rows_i),
    .hi_cyc_i(hi_cyc_i), .lo_cyc_i(lo_cyc_i), .gate_en_o(gate_en_o),
    .vstart_n_o(vstart_n_o), .row_clk_o(row_clk_o), .row_strobe_o(row_strobe_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  // bit order: gate_en, vstart_n, row_clk, strobe, busy, done
  function automatic logic [5:0] outs();
    return {gate_en_o, vstart_n_o, row_clk_o, row_strobe_o, busy_o, done_o};
  endfunction

  task automatic check(input string req, input logic [5:0] exp);
    n_cmp++;
    if (outs() !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, outs(), exp);
    end
  endtask

  // Expected output for cycle k of a frame (k=0 is the cycle after the start edge)
  function automatic logic [5:0] model(input int k, input int nr, input int h, input int l);
    int p = h + l;
    int row = k / p;
    int ph = k % p;
    if (k < nr * p)
      return {1'b1, !(row == 0), (ph < h), (ph == h), 1'b1, 1'b0};
    else if (k == nr * p)
      return 6'b010001;
    else
      return 6'b010000;
  endfunction

  task automatic run_frame(input int r, input int h, input int l, input bit disturb);
    int er = (r == 0) ? 1 : r;
    int eh = (h == 0) ? 1 : h;
    int el = (l == 0) ? 1 : l;
    int total = er * (eh + el);
    string tag;
    tag = disturb ? "R2/R8" : ((r == 0 || h == 0 || l == 0) ? "R9" : "R3/R4/R5/R6");
    @(negedge clk);
    check("R1 idle before frame", 6'b010000);
    rows_i = ROW_W'(r); hi_cyc_i = CNT_W'(h); lo_cyc_i = CNT_W'(l);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k <= total + 1; k++) begin
      if (k > 0) @(negedge clk);
      if (k == total)
        check("R7 done cycle", model(k, er, eh, el));
      else
        check(tag, model(k, er, eh, el));
      if (disturb && (k == 1 || k == total / 2)) begin
        start_i = 1'b1;
        rows_i = ROW_W'(er + 3); hi_cyc_i = CNT_W'(eh + 2); lo_cyc_i = CNT_W'(el + 5);
      end else begin
        start_i = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 6'b010000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", 6'b010000);
    for (int r = 1; r <= 4; r++)
      for (int h = 1; h <= 3; h++)
        for (int l = 1; l <= 4; l++)
          run_frame(r, h, l, 1'b0);
    // R9: zero settings
    run_frame(0, 2, 3, 1'b0);
    run_frame(3, 0, 2, 1'b0);
    run_frame(2, 2, 0, 1'b0);
    run_frame(0, 0, 0, 1'b0);
    // R2, R8: start and setting changes during a frame
    run_frame(3, 2, 4, 1'b1);
    run_frame(5, 1, 3, 1'b1);
    // R7: back-to-back frames, long low phase
    run_frame(2, 1, 9, 1'b0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule